// File: doc/BRIEF.md
# Bounded Descending Hardware Stack

This block is a hardware stack engine for one stack of fixed size. It holds a stack pointer and a private word store, and it carries out push and pop commands that arrive on single-cycle strobes. The stack grows toward lower addresses. The pointer always names the word that is currently on top. When the stack is empty, the pointer sits one word above the highest storage word.

Each command gets a registered response one clock later. A valid strobe comes with a pass/fail bit and, for a pop, the popped word. The engine refuses any command that would run past either bound, and it also refuses simultaneous push and pop. A refused command leaves the pointer and the store exactly as they were. A client can therefore retry, or report the failure, without repairing anything.

Top module: `bounded_stack`

## Requirements
- R1: Synchronous active-low reset sets the pointer to x4000 (empty) and clears resp_valid_o, err_o and data_o. This holds both at power-up and in the middle of a run.
- R2: A push on a non-full stack first lowers the pointer by one, then stores data_i at the new pointer. The first push after reset leaves the pointer at x3FFF.
- R3: A pop on a non-empty stack returns the word at the current pointer on data_o, then raises the pointer by one. Words come back in reverse order of pushing.
- R4: A pop while the pointer is x4000 fails. err_o is 1, data_o is 0 and the pointer stays at x4000.
- R5: A push while the pointer is x3F00 fails. err_o is 1, the pointer stays at x3F00, and the word on top is not overwritten.
- R6: push_i and pop_i high in the same cycle is a failure. err_o is 1, data_o is 0, and neither the pointer nor the store changes.
- R7: Each command cycle produces resp_valid_o=1 in the next cycle. err_o is 0 for a success, and data_o is 0 after a push. A cycle with no command gives resp_valid_o=0 and leaves err_o and data_o unchanged.
- R8: The capacity is 256 words. Starting from empty, 256 pushes succeed and the pointer then reads x3F00. The pointer never leaves the range x3F00 to x4000.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock, rising edge active |
| rst_n | input | 1 | Synchronous active-low reset |
| push_i | input | 1 | Push command strobe |
| pop_i | input | 1 | Pop command strobe |
| data_i | input | DATA_W | Word to push |
| data_o | output | DATA_W | Popped word, or 0 after a push or a failure |
| err_o | output | 1 | Result of last command: 0 success, 1 failure |
| resp_valid_o | output | 1 | High one cycle after each command |
| sp_o | output | ADDR_W | Current stack pointer |

## Verification
The bench builds the engine with its default parameters: 16-bit data and pointer, empty pointer x4000, and 256 words of depth. With these values the full bound at x3F00 is reached after 256 pushes, well inside the run budget. Each storage slot is therefore written and read back once, in reverse order. This brings both refusal edges into reach: the push at exactly x3F00 and the pop at exactly x4000. It also shows that a refused push does not touch the top slot, and that a same-cycle push and pop is refused in the middle of the stack.

// File: rtl/stk_pkg.sv
// Package: shared command type and decode helper for the stack engine.
// Assumes push and pop strobes are single-bit, sampled on the clock edge.
package stk_pkg;

    typedef enum logic [1:0] {
        CMD_IDLE = 2'b00,
        CMD_POP  = 2'b01,
        CMD_PUSH = 2'b10,
        CMD_BOTH = 2'b11
    } stk_cmd_e;

    // Packs the two strobes into a command code.
    function automatic stk_cmd_e stk_decode(input logic push, input logic pop);
        return stk_cmd_e'({push, pop});
    endfunction

endpackage

// File: rtl/stk_guard.sv
// Module: stk_guard
// Decides whether the command of this cycle may proceed, based on the
// pointer bounds. Purely combinational.
// Assumes: EMPTY_PTR > FULL_PTR and the pointer is kept within them.
module stk_guard
    import stk_pkg::*;
#(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] EMPTY_PTR = 16'h4000,
    parameter logic [ADDR_W-1:0] FULL_PTR  = 16'h3F00
) (
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [ADDR_W-1:0] sp_i,
    output logic              push_ok_o,
    output logic              pop_ok_o,
    output logic              fail_o
);

    stk_cmd_e cmd;
    logic     at_empty;
    logic     at_full;

    assign cmd      = stk_decode(push_i, pop_i);
    assign at_empty = (sp_i == EMPTY_PTR);
    assign at_full  = (sp_i == FULL_PTR);

    // Grants or refuses the command from the bound flags.
    always_comb begin
        push_ok_o = 1'b0;
        pop_ok_o  = 1'b0;
        fail_o    = 1'b0;
        unique case (cmd)
            CMD_PUSH: begin
                push_ok_o = !at_full;
                fail_o    = at_full;
            end
            CMD_POP: begin
                pop_ok_o = !at_empty;
                fail_o   = at_empty;
            end
            CMD_BOTH: fail_o = 1'b1;
            default:  fail_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/stk_ptr.sv
// Module: stk_ptr
// Holds the stack pointer: lower by one on a granted push, raise by one on a
// granted pop, otherwise hold. Reset loads the empty value.
// Assumes: at most one of push_ok_i / pop_ok_i is high in a cycle.
module stk_ptr #(
    parameter int ADDR_W = 16,
    parameter logic [ADDR_W-1:0] EMPTY_PTR = 16'h4000,
    parameter logic [ADDR_W-1:0] FULL_PTR  = 16'h3F00
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_ok_i,
    input  logic              pop_ok_i,
    output logic [ADDR_W-1:0] sp_o,
    output logic [ADDR_W-1:0] sp_dec_o
);

    logic [ADDR_W-1:0] sp_q;

    assign sp_o     = sp_q;
    assign sp_dec_o = sp_q - 1'b1;

    // Pointer register update.
    always_ff @(posedge clk) begin
        if (!rst_n)         sp_q <= EMPTY_PTR;
        else if (push_ok_i) sp_q <= sp_dec_o;
        else if (pop_ok_i)  sp_q <= sp_q + 1'b1;
    end

    // R8
    sp_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sp_q >= FULL_PTR) && (sp_q <= EMPTY_PTR));

    // R1
    sp_reset_chk: assert property (@(posedge clk)
        !rst_n |=> (sp_q == EMPTY_PTR));

endmodule

// File: rtl/stk_mem.sv
// Module: stk_mem
// Word store for the stack. One synchronous write port and one
// combinational read port, both indexed by the low address bits.
// Assumes: the region base is aligned to DEPTH, so the low bits map the
// region one-to-one onto the slots.
module stk_mem #(
    parameter int DATA_W = 16,
    parameter int ADDR_W = 16,
    parameter int DEPTH  = 256,
    parameter logic [ADDR_W-1:0] FULL_PTR  = 16'h3F00,
    parameter logic [ADDR_W-1:0] EMPTY_PTR = 16'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [ADDR_W-1:0] waddr_i,
    input  logic [DATA_W-1:0] wdata_i,
    input  logic [ADDR_W-1:0] raddr_i,
    output logic [DATA_W-1:0] rdata_o
);

    localparam int IDX_W = $clog2(DEPTH);

    logic [DATA_W-1:0] slots [DEPTH];
    logic [IDX_W-1:0]  widx;
    logic [IDX_W-1:0]  ridx;

    assign widx    = waddr_i[IDX_W-1:0];
    assign ridx    = raddr_i[IDX_W-1:0];
    assign rdata_o = slots[ridx];

    // Store the pushed word.
    always_ff @(posedge clk) begin
        if (we_i) slots[widx] <= wdata_i;
    end

    // R5
    wr_region_chk: assert property (@(posedge clk) disable iff (!rst_n)
        we_i |-> (waddr_i >= FULL_PTR) && (waddr_i < EMPTY_PTR));

endmodule

// File: rtl/bounded_stack.sv
// Module: bounded_stack (top)
// Full-descending stack with fixed bounds and a registered pass/fail
// response. A refused command changes neither pointer nor store.
// Assumes: commands are one-cycle strobes; the response appears next cycle.
module bounded_stack #(
    parameter int DATA_W    = 16,
    parameter int ADDR_W    = 16,
    parameter int DEPTH     = 256,
    parameter int EMPTY_PTR = 'h4000
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              push_i,
    input  logic              pop_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] data_o,
    output logic              err_o,
    output logic              resp_valid_o,
    output logic [ADDR_W-1:0] sp_o
);

    localparam logic [ADDR_W-1:0] EMPTY_V = ADDR_W'(EMPTY_PTR);
    localparam logic [ADDR_W-1:0] FULL_V  = ADDR_W'(EMPTY_PTR - DEPTH);

    logic              push_ok;
    logic              pop_ok;
    logic              fail;
    logic [ADDR_W-1:0] sp;
    logic [ADDR_W-1:0] sp_dec;
    logic [DATA_W-1:0] rdata;
    logic              valid_q;
    logic              err_q;
    logic [DATA_W-1:0] dout_q;

    stk_guard #(.ADDR_W(ADDR_W), .EMPTY_PTR(EMPTY_V), .FULL_PTR(FULL_V)) u_guard (
        .push_i   (push_i),
        .pop_i    (pop_i),
        .sp_i     (sp),
        .push_ok_o(push_ok),
        .pop_ok_o (pop_ok),
        .fail_o   (fail)
    );

    stk_ptr #(.ADDR_W(ADDR_W), .EMPTY_PTR(EMPTY_V), .FULL_PTR(FULL_V)) u_ptr (
        .clk      (clk),
        .rst_n    (rst_n),
        .push_ok_i(push_ok),
        .pop_ok_i (pop_ok),
        .sp_o     (sp),
        .sp_dec_o (sp_dec)
    );

    stk_mem #(.DATA_W(DATA_W), .ADDR_W(ADDR_W), .DEPTH(DEPTH),
              .FULL_PTR(FULL_V), .EMPTY_PTR(EMPTY_V)) u_mem (
        .clk    (clk),
        .rst_n  (rst_n),
        .we_i   (push_ok),
        .waddr_i(sp_dec),
        .wdata_i(data_i),
        .raddr_i(sp),
        .rdata_o(rdata)
    );

    // Registered response: valid strobe, status and popped word.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            valid_q <= 1'b0;
            err_q   <= 1'b0;
            dout_q  <= '0;
        end else begin
            valid_q <= push_i | pop_i;
            if (push_i | pop_i) begin
                err_q  <= fail;
                dout_q <= pop_ok ? rdata : '0;
            end
        end
    end

    assign data_o       = dout_q;
    assign err_o        = err_q;
    assign resp_valid_o = valid_q;
    assign sp_o         = sp;

    // R4
    fail_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (resp_valid_o && err_o) |-> ($stable(sp_o) && (data_o == '0)));

    // R6
    dual_cmd_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && pop_i) |=> (resp_valid_o && err_o));

    // R2
    push_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (push_i && !pop_i && sp_o != FULL_V) |=> (sp_o == $past(sp_o) - 1'b1) && !err_o);

    // R3
    pop_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (pop_i && !push_i && sp_o != EMPTY_V) |=> (sp_o == $past(sp_o) + 1'b1) && !err_o);

    // R7
    idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!push_i && !pop_i) |=> (!resp_valid_o && $stable(err_o) && $stable(data_o)));

endmodule

// File: tb/bounded_stack_test.sv
`timescale 1ns/1ps
module bounded_stack_test;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        push_i = 1'b0;
    logic        pop_i = 1'b0;
    logic [15:0] data_i = '0;
    logic [15:0] data_o;
    logic        err_o;
    logic        resp_valid_o;
    logic [15:0] sp_o;

    int checks = 0;
    int failures = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    bounded_stack uut (
        .clk(clk), .rst_n(rst_n), .push_i(push_i), .pop_i(pop_i),
        .data_i(data_i), .data_o(data_o), .err_o(err_o),
        .resp_valid_o(resp_valid_o), .sp_o(sp_o)
    );

    typedef struct packed {
        logic        push;
        logic        pop;
        logic [15:0] din;
        logic        exp_err;
        logic [15:0] exp_dout;
        logic [15:0] exp_sp;
        logic [3:0]  req;
    } vec_t;

    // Rows: pop empty (R4), pushes (R2), both (R6), pops LIFO (R3), pop empty (R4)
    localparam int NV = 11;
    localparam vec_t TBL [NV] = '{
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000, 16'h4000, 4'd4},
        '{1'b1, 1'b0, 16'hA111, 1'b0, 16'h0000, 16'h3FFF, 4'd2},
        '{1'b1, 1'b0, 16'hB222, 1'b0, 16'h0000, 16'h3FFE, 4'd2},
        '{1'b1, 1'b1, 16'hEEEE, 1'b1, 16'h0000, 16'h3FFE, 4'd6},
        '{1'b1, 1'b0, 16'hC333, 1'b0, 16'h0000, 16'h3FFD, 4'd2},
        '{1'b0, 1'b1, 16'h0000, 1'b0, 16'hC333, 16'h3FFE, 4'd3},
        '{1'b0, 1'b1, 16'h0000, 1'b0, 16'hB222, 16'h3FFF, 4'd3},
        '{1'b1, 1'b0, 16'hD444, 1'b0, 16'h0000, 16'h3FFE, 4'd2},
        '{1'b0, 1'b1, 16'h0000, 1'b0, 16'hD444, 16'h3FFF, 4'd3},
        '{1'b0, 1'b1, 16'h0000, 1'b0, 16'hA111, 16'h4000, 4'd3},
        '{1'b0, 1'b1, 16'h0000, 1'b1, 16'h0000, 16'h4000, 4'd4}
    };

    task automatic check(input string req, input string what,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
        end
    endtask

    // Drive one command at a negedge; the response is sampled at the next negedge.
    task automatic issue(input logic p, input logic q, input logic [15:0] d);
        push_i = p; pop_i = q; data_i = d;
        @(negedge clk);
        push_i = 1'b0; pop_i = 1'b0; data_i = '0;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    initial begin
        #(200000 * 5.0);
        failures++;
        $display("FAIL watchdog expired actual=running expected=done");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1", "sp", sp_o, 16'h4000);
        check("R1", "err", {15'd0, err_o}, 16'd0);
        check("R1", "valid", {15'd0, resp_valid_o}, 16'd0);
        check("R1", "dout", data_o, 16'd0);

        for (int i = 0; i < NV; i++) begin
            string rq;
            rq = $sformatf("R%0d", TBL[i].req);
            issue(TBL[i].push, TBL[i].pop, TBL[i].din);
            check("R7", "valid", {15'd0, resp_valid_o}, 16'd1);
            check(rq, "err", {15'd0, err_o}, {15'd0, TBL[i].exp_err});
            check(rq, "dout", data_o, TBL[i].exp_dout);
            check(rq, "sp", sp_o, TBL[i].exp_sp);
        end

        // R7 idle cycle: no valid, status and data held (last was failed pop)
        @(negedge clk);
        check("R7", "idle valid", {15'd0, resp_valid_o}, 16'd0);
        check("R7", "idle err", {15'd0, err_o}, 16'd1);

        // R8 fill to capacity
        for (int i = 0; i < 256; i++) begin
            issue(1'b1, 1'b0, 16'(i + 16'h1000));
            if (err_o !== 1'b0)
                check("R8", "fill err", {15'd0, err_o}, 16'd0);
        end
        check("R8", "full sp", sp_o, 16'h3F00);

        // R5 push on full is refused and does not overwrite the top
        issue(1'b1, 1'b0, 16'hFFFF);
        check("R5", "err", {15'd0, err_o}, 16'd1);
        check("R5", "sp", sp_o, 16'h3F00);
        issue(1'b0, 1'b1, 16'h0);
        check("R5", "top kept", data_o, 16'h10FF);

        // R6 both strobes mid-stack
        issue(1'b1, 1'b1, 16'h5555);
        check("R6", "err", {15'd0, err_o}, 16'd1);
        check("R6", "sp", sp_o, 16'h3F01);

        // R3 drain remaining words in reverse order
        for (int i = 254; i >= 0; i--) begin
            issue(1'b0, 1'b1, 16'h0);
            if (data_o !== 16'(i + 16'h1000) || err_o !== 1'b0)
                check("R3", "drain", data_o, 16'(i + 16'h1000));
        end
        check("R3", "drained sp", sp_o, 16'h4000);
        issue(1'b0, 1'b1, 16'h0);
        check("R4", "err after drain", {15'd0, err_o}, 16'd1);

        // R1 reset in mid-run
        issue(1'b1, 1'b0, 16'h7777);
        check("R2", "push before reset", sp_o, 16'h3FFF);
        rst_n = 1'b0;
        @(negedge clk);
        rst_n = 1'b1;
        check("R1", "mid sp", sp_o, 16'h4000);
        check("R1", "mid valid", {15'd0, resp_valid_o}, 16'd0);

        finish_run();
    end

endmodule